// File: doc/BRIEF.md
# Parallel Priority Interrupt Controller

This block collects interrupt requests from a small fixed set of devices. It keeps one pending bit per device and one enable bit per device. The enabled pending bits go to a fixed-priority encoder. Device 0 has the highest priority and the highest index the lowest. A registered status bit records that some enabled request is waiting. The CPU interrupt line is that status bit ANDed with a global enable flip-flop.

The CPU programs the block through a one-cycle write port. One operation code loads the whole per-device enable (mask) register. A second clears chosen pending bits. A third loads the global enable. When the CPU acknowledges, the block drives a vector on the next cycle. The vector is a fixed base in the upper bits joined to the encoder's index in the low bits. At all other times the bus output is zero and its drive flag is low.

Top module: `ppi_ctrl`

## Requirements
- R1: A synchronous reset clears every pending bit, every mask bit (all sources disabled), the global enable and the status bit. The cycle after a reset edge, `cpu_int`, `vec_drive` and `vec_out` are all 0.
- R2: A sampled high on `irq_in[i]` sets pending bit i at that edge. The bit stays set after the request drops, until a clear write names it.
- R3: If a device sets a pending bit in the same cycle that a clear write (`wr_op`=2'b01) names it, the bit stays set.
- R4: A write with `wr_op`=2'b00 loads `wr_data` into the mask, where 1 enables a source. A pending bit whose mask bit is 0 neither raises the status bit nor is chosen for the vector.
- R5: Among sources that are both pending and enabled, the lowest index is encoded into the low vector bits.
- R6: The status bit is recomputed at every edge as the OR of the enabled pending bits before that edge. It therefore follows them with one cycle of delay and falls once none remain.
- R7: A write with `wr_op`=2'b10 loads `wr_data[0]` into the global enable. `cpu_int` is high only while both the status bit and the global enable are 1.
- R8: In the cycle after `intack` is sampled high, `vec_drive` is 1 and `vec_out` is {`VEC_BASE`, code}. The code is the encoder result taken from the state before that edge, or 0 if no enabled request is pending. In the cycle after `intack` is sampled low, `vec_drive` and `vec_out` are 0.
- R9: A write with `wr_op`=2'b11 changes neither the pending bits, the mask nor the global enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_SRC | Device request lines, bit 0 highest priority |
| wr_en | input | 1 | Write strobe for the program port |
| wr_op | input | 2 | Operation: 00 load mask, 01 clear pending, 10 load global enable, 11 none |
| wr_data | input | N_SRC | Write data for the selected operation |
| intack | input | 1 | Interrupt acknowledge from the CPU |
| cpu_int | output | 1 | Interrupt request to the CPU |
| vec_out | output | VEC_W | Vector address bus, zero when not driven |
| vec_drive | output | 1 | High while the vector is placed on the bus |

## Verification
On every cycle the assertions check the following:
- each sampled request lands in the pending bits, even against a clear in the same cycle;
- pending bits never drop without a clear write;
- `cpu_int` goes low after the global enable is written to 0;
- `cpu_int` never rises without enabled requests pending one cycle earlier;
- every driven vector carries the base and the lowest-index active source.

Some behaviour only the scripted scenarios can show:
- the exact latency of the status bit after a mask change;
- that masked sources stay hidden until re-enabled;
- that the no-operation code leaves the programmed state intact;
- that a reset in the middle of a run restores the all-masked, disabled state.

// File: rtl/ppi_pkg.sv
package ppi_pkg;

  // Program-port operation codes
  typedef enum logic [1:0] {
    OP_MASK   = 2'b00,
    OP_CLEAR  = 2'b01,
    OP_ENABLE = 2'b10,
    OP_NONE   = 2'b11
  } ppi_op_e;

endpackage

// File: rtl/ppi_src_bank.sv
module ppi_src_bank #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req,
  input  logic             wr_en,
  input  ppi_pkg::ppi_op_e wr_op,
  input  logic [N_SRC-1:0] wr_data,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] mask_o
);
  import ppi_pkg::*;

  logic mask_load;
  logic pend_clear;

  assign mask_load  = wr_en && (wr_op == OP_MASK);
  assign pend_clear = wr_en && (wr_op == OP_CLEAR);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic pend_q;
    logic mask_q;

    // A device set overrides a program clear in the same cycle
    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q <= 1'b0;
      end else if (req[g]) begin
        pend_q <= 1'b1;
      end else if (pend_clear && wr_data[g]) begin
        pend_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q <= 1'b0;
      end else if (mask_load) begin
        mask_q <= wr_data[g];
      end
    end

    assign pend_o[g] = pend_q;
    assign mask_o[g] = mask_q;
  end

endmodule

// File: rtl/ppi_prio_enc.sv
module ppi_prio_enc #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned CODE_W = 2
) (
  input  logic [N_SRC-1:0]  act,
  output logic [CODE_W-1:0] code,
  output logic              any
);

  // Scan from the lowest priority up so the lowest index is written last
  always_comb begin
    code = '0;
    any  = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (act[i]) begin
        code = CODE_W'(i);
        any  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/ppi_vec_drv.sv
module ppi_vec_drv #(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned CODE_W = 2,
  parameter int unsigned BASE_W = 6,
  parameter logic [BASE_W-1:0] BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack,
  input  logic [CODE_W-1:0] code,
  output logic [VEC_W-1:0]  vec_o,
  output logic              drive_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_o   <= '0;
      drive_o <= 1'b0;
    end else begin
      drive_o <= ack;
      vec_o   <= ack ? {BASE, code} : '0;
    end
  end

endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl #(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 'h2D
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_op,
  input  logic [N_SRC-1:0] wr_data,
  input  logic             intack,
  output logic             cpu_int,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_drive
);
  import ppi_pkg::*;

  localparam int unsigned CODE_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int unsigned BASE_W = VEC_W - CODE_W;
  localparam logic [BASE_W-1:0] BASE_BITS = BASE_W'(VEC_BASE);

  ppi_op_e           op;
  logic [N_SRC-1:0]  pend_q;
  logic [N_SRC-1:0]  mask_q;
  logic [N_SRC-1:0]  act;
  logic [CODE_W-1:0] code;
  logic              any_act;
  logic              ien_q;
  logic              ist_q;

  assign op  = ppi_op_e'(wr_op);
  assign act = pend_q & mask_q;

  ppi_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .req     (irq_in),
    .wr_en   (wr_en),
    .wr_op   (op),
    .wr_data (wr_data),
    .pend_o  (pend_q),
    .mask_o  (mask_q)
  );

  ppi_prio_enc #(.N_SRC(N_SRC), .CODE_W(CODE_W)) u_enc (
    .act  (act),
    .code (code),
    .any  (any_act)
  );

  ppi_vec_drv #(
    .VEC_W (VEC_W),
    .CODE_W(CODE_W),
    .BASE_W(BASE_W),
    .BASE  (BASE_BITS)
  ) u_vec (
    .clk     (clk),
    .rst     (rst),
    .ack     (intack),
    .code    (code),
    .vec_o   (vec_out),
    .drive_o (vec_drive)
  );

  // Status flip-flop follows the enabled pending bits every cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      ist_q <= 1'b0;
    end else begin
      ist_q <= any_act;
    end
  end

  // Global enable, program controlled
  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 1'b0;
    end else if (wr_en && (op == OP_ENABLE)) begin
      ien_q <= wr_data[0];
    end
  end

  assign cpu_int = ist_q & ien_q;

endmodule

// File: rtl/ppi_ctrl_chk.sv
module ppi_ctrl_chk #(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 'h2D
) (
  input logic             clk,
  input logic             rst,
  input logic [N_SRC-1:0] irq_in,
  input logic             wr_en,
  input logic [1:0]       wr_op,
  input logic [N_SRC-1:0] wr_data,
  input logic             intack,
  input logic             cpu_int,
  input logic [VEC_W-1:0] vec_out,
  input logic             vec_drive,
  input logic [N_SRC-1:0] pend,
  input logic [N_SRC-1:0] mask
);
  localparam int unsigned CODE_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int unsigned BASE_W = VEC_W - CODE_W;
  localparam logic [BASE_W-1:0] BASE_BITS = BASE_W'(VEC_BASE);

  logic [N_SRC-1:0]  act_seen;
  logic [CODE_W-1:0] got_code;
  logic [N_SRC-1:0]  below;
  logic              clr_wr;

  always_ff @(posedge clk) begin
    if (rst) act_seen <= '0;
    else     act_seen <= pend & mask;
  end

  assign got_code = vec_out[CODE_W-1:0];
  assign below    = (N_SRC'(1) << got_code) - N_SRC'(1);
  assign clr_wr   = wr_en && (wr_op == 2'b01);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!cpu_int && !vec_drive && vec_out == '0));

  // R2
  a_r2_request_lands: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & $past(irq_in)) == $past(irq_in)));

  a_r2_pending_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((pend & $past(pend)) == $past(pend)));

  // R3
  a_r3_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((pend & $past(irq_in & wr_data)) == $past(irq_in & wr_data)));

  // R5
  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    (vec_drive && act_seen != '0) |-> (act_seen[got_code] && ((act_seen & below) == '0)));

  // R6
  a_r6_int_needs_active: assert property (@(posedge clk) disable iff (rst)
    cpu_int |-> ($past(pend & mask) != '0));

  // R7
  a_r7_disable_drops_int: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_op == 2'b10 && !wr_data[0]) |=> !cpu_int);

  // R8
  a_r8_ack_drives: assert property (@(posedge clk) disable iff (rst)
    intack |=> vec_drive);

  a_r8_idle_bus: assert property (@(posedge clk) disable iff (rst)
    !intack |=> (!vec_drive && vec_out == '0));

  a_r8_base_bits: assert property (@(posedge clk) disable iff (rst)
    vec_drive |-> (vec_out[VEC_W-1:CODE_W] == BASE_BITS));

endmodule

bind ppi_ctrl ppi_ctrl_chk #(
  .N_SRC   (N_SRC),
  .VEC_W   (VEC_W),
  .VEC_BASE(VEC_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_in    (irq_in),
  .wr_en     (wr_en),
  .wr_op     (wr_op),
  .wr_data   (wr_data),
  .intack    (intack),
  .cpu_int   (cpu_int),
  .vec_out   (vec_out),
  .vec_drive (vec_drive),
  .pend      (pend_q),
  .mask      (mask_q)
);

// File: tb/ppi_ctrl_test.sv
`timescale 1ns/1ps
module ppi_ctrl_test;

  localparam int unsigned NS = 4;
  localparam int unsigned VW = 8;
  // Base 0x2D in bits 7:2 gives vectors 0xB4..0xB7 for sources 0..3
  localparam logic [7:0] V0 = 8'hB4;
  localparam logic [7:0] V1 = 8'hB5;
  localparam logic [7:0] V2 = 8'hB6;
  localparam logic [7:0] V3 = 8'hB7;

  localparam logic [1:0] OPM = 2'b00;
  localparam logic [1:0] OPC = 2'b01;
  localparam logic [1:0] OPE = 2'b10;
  localparam logic [1:0] OPN = 2'b11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] irq = '0;
  logic          we  = 1'b0;
  logic [1:0]    op  = OPN;
  logic [NS-1:0] wd  = '0;
  logic          ack = 1'b0;
  logic          cpu_int;
  logic [VW-1:0] vec_out;
  logic          vec_drive;

  typedef struct {
    string      tag;
    logic       e_int;
    logic       e_drv;
    logic [7:0] e_vec;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  always #2.5 clk = ~clk;

  ppi_ctrl #(.N_SRC(NS), .VEC_W(VW), .VEC_BASE('h2D)) uut (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq),
    .wr_en     (we),
    .wr_op     (op),
    .wr_data   (wd),
    .intack    (ack),
    .cpu_int   (cpu_int),
    .vec_out   (vec_out),
    .vec_drive (vec_drive)
  );

  // Driver: inputs are already set for this cycle; push what the outputs must
  // show after the coming edge, then return the one-cycle inputs to idle.
  task automatic go(input string tag, input logic ei, input logic ed, input logic [7:0] ev);
    exp_t it;
    it.tag = tag; it.e_int = ei; it.e_drv = ed; it.e_vec = ev;
    exp_q.push_back(it);
    @(negedge clk);
    irq = '0; we = 1'b0; op = OPN; wd = '0; ack = 1'b0;
  endtask

  task automatic wr(input logic [1:0] o, input logic [NS-1:0] d);
    we = 1'b1; op = o; wd = d;
  endtask

  // Monitor: pops one expectation per edge and compares just after it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        n_chk++;
        if (cpu_int !== it.e_int || vec_drive !== it.e_drv || vec_out !== it.e_vec) begin
          n_fail++;
          $display("FAIL %s: got int=%b drv=%b vec=%h, expected int=%b drv=%b vec=%h",
                   it.tag, cpu_int, vec_drive, vec_out, it.e_int, it.e_drv, it.e_vec);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    go("R1 reset state", 0, 0, 8'h00);
    rst = 1'b0;
    ack = 1;                        go("R8 ack with nothing pending", 0, 1, V0);
    irq = 4'b0100;                  go("R8 bus idle without ack", 0, 0, 8'h00);
    wr(OPE, 4'b0001);               go("R4 masked source raises nothing", 0, 0, 8'h00);
    ack = 1;                        go("R4 masked source not encoded", 0, 1, V0);
    wr(OPM, 4'b1111);               go("R6 status lags mask load", 0, 0, 8'h00);
    go("R6 status set one cycle later", 1, 0, 8'h00);
    ack = 1;                        go("R8 vector for source 2", 1, 1, V2);
    irq = 4'b1010; ack = 1;         go("R8 vector uses state before edge", 1, 1, V2);
    ack = 1;                        go("R5 source 1 beats 2 and 3", 1, 1, V1);
    irq = 4'b0001; ack = 1;         go("R5 old state still encoded", 1, 1, V1);
    ack = 1;                        go("R5 source 0 wins", 1, 1, V0);
    irq = 4'b0001; wr(OPC, 4'b0001); ack = 1; go("R3 set and clear together", 1, 1, V0);
    ack = 1;                        go("R3 set kept over clear", 1, 1, V0);
    wr(OPC, 4'b0011); ack = 1;      go("R2 clear write, old state", 1, 1, V0);
    ack = 1;                        go("R2 cleared bits leave source 2", 1, 1, V2);
    wr(OPN, 4'b1111); ack = 1;      go("R9 no-op write cycle", 1, 1, V2);
    ack = 1;                        go("R9 no-op left state intact", 1, 1, V2);
    wr(OPM, 4'b1011); ack = 1;      go("R4 mask update, old state", 1, 1, V2);
    ack = 1;                        go("R4 masked source 2 skipped", 1, 1, V3);
    wr(OPE, 4'b0000);               go("R7 global enable off", 0, 0, 8'h00);
    go("R7 interrupt stays off", 0, 0, 8'h00);
    wr(OPE, 4'b0001);               go("R7 global enable back on", 1, 0, 8'h00);
    wr(OPC, 4'b1111);               go("R6 status holds one cycle", 1, 0, 8'h00);
    go("R6 status falls when none remain", 0, 0, 8'h00);
    ack = 1;                        go("R8 empty ack gives code 0", 0, 1, V0);
    irq = 4'b0010;                  go("R2 request captured", 0, 0, 8'h00);
    go("R2 pending after request drops", 1, 0, 8'h00);
    go("R2 pending still held", 1, 0, 8'h00);
    ack = 1;                        go("R2 held request encoded", 1, 1, V1);
    rst = 1'b1; ack = 1;            go("R1 reset mid-run", 0, 0, 8'h00);
    rst = 1'b0;
    irq = 4'b1111;                  go("R1 requests after reset", 0, 0, 8'h00);
    wr(OPE, 4'b0001);               go("R1 mask cleared by reset", 0, 0, 8'h00);
    ack = 1;                        go("R1 all sources masked after reset", 0, 1, V0);
    go("R1 final idle", 0, 0, 8'h00);
    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule